// File: doc/BRIEF.md
# Power-Mode Supervisor State Machine

This block decides which power mode a supervised system is in. It moves between four modes: reset, run, wait and standby. From the mode it drives these outputs: the main power-enable pin, an active-low change-indicator pin with its own output enable, a reset pulse for the rest of the system, and enables for the watchdog and for an external delay timer.

While the system runs, the block keeps two saturating error counters. One counts watchdog timeouts. The other counts serial-bus errors and missed host acknowledgements. If either counter fills, or the oscillator reports a fault, the system is sent back through reset.

A host control bit sends the system to sleep. The delay timer, the external reset line and the wake sources then move it on to standby or back to run. In standby, any change on the eight wake inputs, an impedance detection, an alarm event or an oscillator fault restarts the system.

Top module: `pwr_mode_sup`

## Requirements
- R1: A low level on `arst_n` puts the block at once into mode 0 (reset), with both counters at 0 and the reset pulse low. The first clock after release moves it to mode 1 (run). Mode codes are 0 reset, 1 run, 2 wait, 3 standby, shown on `mode_o`.
- R2: In run, `pwr_en_o`, `chg_oe_o`, `wd_en_o` and `dly_en_o` are high and `chg_n_o` is low. In every other mode, `pwr_en_o`, `chg_oe_o` and `wd_en_o` are low, and `dly_en_o` is high only in wait.
- R3: Leaving reset starts `rst_pulse_o`. It stays high for exactly PULSE_LEN clocks (16 by default) and keeps counting even if the mode changes meanwhile.
- R4: In run, each `wd_tmo_i` strobe adds one to the watchdog error count, which saturates at 5. A `wd_kick_i` clears the count, but a timeout in the same cycle wins.
- R5: In run, each `bus_err_i` strobe or missed acknowledgement adds one to the bus error count, which saturates at 5.
- R6: In run, a count at 5 or an `osc_fault_i` strobe sends the block to reset on the next clock.
- R7: Both counters read 0 from the first clock spent in any mode other than run. Error strobes outside run have no effect.
- R8: In run, wake-input changes, `imp_det_i` and `alarm_i` have no effect on the mode.
- R9: After run is entered, if no `host_acc_i` arrives, a bus error is counted in the ACK_WAIT-th run cycle (32nd by default). This repeats every ACK_WAIT cycles until an acknowledge arrives.
- R10: In run with no error or fault, `sleep_req_i` moves the block to wait on the next clock. `dly_start_o` is high during the first wait cycle only.
- R11: In wait, `dly_done_i`, a low `res_n` or `osc_fault_i` moves the block to standby. Otherwise `wake_i[0]` at 1 moves it to reset.
- R12: In standby, a change on any `wake_i` bit since the previous clock, `imp_det_i`, `alarm_i` or `osc_fault_i` moves the block to reset. Otherwise it stays in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset request, active low |
| res_n | input | 1 | External reset line level, examined in wait |
| wake_i | input | NWAKE | Wake inputs |
| imp_det_i | input | 1 | Impedance detection strobe |
| alarm_i | input | 1 | Alarm compare strobe |
| osc_fault_i | input | 1 | Oscillator fault strobe |
| wd_kick_i | input | 1 | Watchdog service strobe |
| wd_tmo_i | input | 1 | Watchdog timeout strobe |
| bus_err_i | input | 1 | Serial-bus error strobe |
| host_acc_i | input | 1 | Host acknowledge of the change indicator |
| sleep_req_i | input | 1 | Host control bit requesting sleep |
| dly_done_i | input | 1 | Delay timer expiry |
| pwr_en_o | output | 1 | Power enable, active high |
| chg_n_o | output | 1 | Change indicator, active low |
| chg_oe_o | output | 1 | Output enable of the change indicator |
| rst_pulse_o | output | 1 | Generated system reset pulse |
| wd_en_o | output | 1 | Watchdog enable |
| dly_en_o | output | 1 | Delay timer function enable |
| dly_start_o | output | 1 | One-cycle delay timer start |
| mode_o | output | 2 | Current mode code |
| wd_err_o | output | ERR_W | Watchdog error count |
| bus_err_o | output | ERR_W | Bus error count |

## Verification
The hardest state to reach from the ports is the acknowledge deadline. It needs a long stretch of run with no host acknowledge, five deadline expiries in a row, and a check that the fifth expiry is what forces the return through reset. The stimulus enters run and then withholds `host_acc_i` for more than 160 cycles. Every cycle, the expected bus count is derived from how long the block has been in run, so each step of the count and the final exit fall on exact cycles. The other hard cases are the standby wake sources. To reach them, the bench first leads the block through wait, each time by a different exit path (delay timer end, reset line low).

// File: rtl/pwr_mode_sup.sv
module pwr_mode_sup #(
  parameter int NWAKE     = 8,
  parameter int ERR_LIMIT = 5,
  parameter int PULSE_LEN = 16,
  parameter int ACK_WAIT  = 32,
  localparam int ERR_W    = $clog2(ERR_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             res_n,
  input  logic [NWAKE-1:0] wake_i,
  input  logic             imp_det_i,
  input  logic             alarm_i,
  input  logic             osc_fault_i,
  input  logic             wd_kick_i,
  input  logic             wd_tmo_i,
  input  logic             bus_err_i,
  input  logic             host_acc_i,
  input  logic             sleep_req_i,
  input  logic             dly_done_i,
  output logic             pwr_en_o,
  output logic             chg_n_o,
  output logic             chg_oe_o,
  output logic             rst_pulse_o,
  output logic             wd_en_o,
  output logic             dly_en_o,
  output logic             dly_start_o,
  output logic [1:0]       mode_o,
  output logic [ERR_W-1:0] wd_err_o,
  output logic [ERR_W-1:0] bus_err_o
);
  localparam int PL_W = $clog2(PULSE_LEN + 1);
  localparam int AW   = $clog2(ACK_WAIT);
  localparam logic [1:0] M_RESET = 2'd0;
  localparam logic [1:0] M_RUN   = 2'd1;
  localparam logic [1:0] M_WAIT  = 2'd2;
  localparam logic [1:0] M_STBY  = 2'd3;
  localparam logic [ERR_W-1:0] LIM = ERR_W'(ERR_LIMIT);

  logic [1:0]       mode_q, mode_d;
  logic [NWAKE-1:0] wake_q;
  logic [ERR_W-1:0] wd_q, bus_q;
  logic [PL_W-1:0]  pcnt_q;
  logic [AW-1:0]    ack_cnt_q;
  logic             acked_q;
  logic             dstart_q;

  wire in_run   = (mode_q == M_RUN);
  wire wake_evt = (|(wake_i ^ wake_q)) | imp_det_i | alarm_i | osc_fault_i;
  wire ack_miss = in_run && !acked_q && (ack_cnt_q == AW'(ACK_WAIT - 1));
  wire err_full = (wd_q == LIM) || (bus_q == LIM);

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      M_RESET: mode_d = M_RUN;
      M_RUN: begin
        if (err_full || osc_fault_i) mode_d = M_RESET;
        else if (sleep_req_i)        mode_d = M_WAIT;
      end
      M_WAIT: begin
        if (dly_done_i || !res_n || osc_fault_i) mode_d = M_STBY;
        else if (wake_i[0])                      mode_d = M_RESET;
      end
      default: if (wake_evt) mode_d = M_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mode_q   <= M_RESET;
      wake_q   <= '0;
      dstart_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      wake_q   <= wake_i;
      dstart_q <= in_run && (mode_d == M_WAIT);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wd_q  <= '0;
      bus_q <= '0;
    end else if (!in_run) begin
      wd_q  <= '0;
      bus_q <= '0;
    end else begin
      if (wd_tmo_i) begin
        if (wd_q != LIM) wd_q <= wd_q + 1'b1;
      end else if (wd_kick_i) begin
        wd_q <= '0;
      end
      if ((bus_err_i || ack_miss) && bus_q != LIM) bus_q <= bus_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                pcnt_q <= '0;
    else if (mode_q == M_RESET) pcnt_q <= PL_W'(PULSE_LEN);
    else if (pcnt_q != '0)      pcnt_q <= pcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ack_cnt_q <= '0;
      acked_q   <= 1'b0;
    end else if (!in_run) begin
      ack_cnt_q <= '0;
      acked_q   <= 1'b0;
    end else begin
      if (host_acc_i) acked_q <= 1'b1;
      if (ack_miss)     ack_cnt_q <= '0;
      else if (!acked_q) ack_cnt_q <= ack_cnt_q + 1'b1;
    end
  end

  assign pwr_en_o    = in_run;
  assign chg_oe_o    = in_run;
  assign chg_n_o     = !in_run;
  assign wd_en_o     = in_run;
  assign dly_en_o    = in_run || (mode_q == M_WAIT);
  assign dly_start_o = dstart_q;
  assign rst_pulse_o = (pcnt_q != '0);
  assign mode_o      = mode_q;
  assign wd_err_o    = wd_q;
  assign bus_err_o   = bus_q;
endmodule

// File: rtl/pwr_mode_sup_chk.sv
module pwr_mode_sup_chk #(
  parameter int ERR_LIMIT = 5,
  parameter int EW        = 3
) (
  input logic          clk,
  input logic          arst_n,
  input logic          osc_fault_i,
  input logic [1:0]    mode_o,
  input logic [EW-1:0] wd_err_o,
  input logic [EW-1:0] bus_err_o,
  input logic          rst_pulse_o,
  input logic          dly_start_o
);
  assert_reset_to_run_R1: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o == 2'd0) |=> (mode_o == 2'd1));

  assert_entry_pulse_R3: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o == 2'd0) |=> rst_pulse_o);

  always_comb begin
    if (arst_n) begin
      assert_wd_sat_R4: assert (wd_err_o <= EW'(ERR_LIMIT));
      assert_bus_sat_R5: assert (bus_err_o <= EW'(ERR_LIMIT));
    end
  end

  assert_wd_exit_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o == 2'd1 && wd_err_o == EW'(ERR_LIMIT)) |=> (mode_o == 2'd0));

  assert_bus_exit_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o == 2'd1 && bus_err_o == EW'(ERR_LIMIT)) |=> (mode_o == 2'd0));

  assert_osc_exit_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o == 2'd1 && osc_fault_i) |=> (mode_o == 2'd0));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (mode_o != 2'd1) |=> (wd_err_o == '0 && bus_err_o == '0));

  assert_wait_entry_R10: assert property (@(posedge clk) disable iff (!arst_n)
    dly_start_o |-> (mode_o == 2'd2 && $past(mode_o) == 2'd1));
endmodule

bind pwr_mode_sup pwr_mode_sup_chk #(.ERR_LIMIT(ERR_LIMIT), .EW(ERR_W)) u_chk (
  .clk(clk), .arst_n(arst_n), .osc_fault_i(osc_fault_i), .mode_o(mode_o),
  .wd_err_o(wd_err_o), .bus_err_o(bus_err_o), .rst_pulse_o(rst_pulse_o),
  .dly_start_o(dly_start_o)
);

// File: tb/tb_pwr_mode_sup.sv
`timescale 1ns/1ps
module tb_pwr_mode_sup;
  localparam logic [1:0] RST = 2'd0, RUN = 2'd1, WT = 2'd2, SB = 2'd3;

  logic clk = 1'b0;
  logic arst_n = 1'b0, res_n = 1'b1;
  logic [7:0] wake = '0;
  logic imp = 0, alarm = 0, osc = 0, kick = 0, tmo = 0, berr = 0, acc = 0, sleep = 0, ddone = 0;
  logic pwr_en, chg_n, chg_oe, rst_pulse, wd_en, dly_en, dly_start;
  logic [1:0] mode;
  logic [2:0] wd_cnt, bus_cnt;

  int checks = 0, errors = 0, age = 100;
  bit done = 0;

  typedef struct {
    logic [1:0] m;
    int wd;
    int bus;
    bit pulse;
    bit ds;
    string tag;
  } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;

  pwr_mode_sup dut (
    .clk(clk), .arst_n(arst_n), .res_n(res_n), .wake_i(wake), .imp_det_i(imp),
    .alarm_i(alarm), .osc_fault_i(osc), .wd_kick_i(kick), .wd_tmo_i(tmo),
    .bus_err_i(berr), .host_acc_i(acc), .sleep_req_i(sleep), .dly_done_i(ddone),
    .pwr_en_o(pwr_en), .chg_n_o(chg_n), .chg_oe_o(chg_oe), .rst_pulse_o(rst_pulse),
    .wd_en_o(wd_en), .dly_en_o(dly_en), .dly_start_o(dly_start), .mode_o(mode),
    .wd_err_o(wd_cnt), .bus_err_o(bus_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input int wd, input int bus, input bit ds, input string tag);
    exp_t e;
    e.m = m; e.wd = wd; e.bus = bus; e.ds = ds; e.tag = tag;
    e.pulse = (age < 16);
    age++;
    sbq.push_back(e);
    @(negedge clk);
    imp = 0; alarm = 0; osc = 0; kick = 0; tmo = 0; berr = 0; acc = 0; ddone = 0;
  endtask

  task automatic enter_run(input string tag);
    age = 0;
    step(RUN, 0, 0, 0, tag);
    acc = 1;
    step(RUN, 0, 0, 0, {tag, " ack R9"});
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        chk(mode == e.m, {e.tag, " mode R1"}, mode, e.m);
        chk(pwr_en == (e.m == RUN), {e.tag, " pwr_en R2"}, pwr_en, e.m == RUN);
        chk(chg_oe == (e.m == RUN), {e.tag, " chg_oe R2"}, chg_oe, e.m == RUN);
        if (e.m == RUN) chk(chg_n == 1'b0, {e.tag, " chg_n R2"}, chg_n, 0);
        chk(wd_en == (e.m == RUN), {e.tag, " wd_en R2"}, wd_en, e.m == RUN);
        chk(dly_en == (e.m == RUN || e.m == WT), {e.tag, " dly_en R2"}, dly_en, e.m == RUN || e.m == WT);
        chk(rst_pulse == e.pulse, {e.tag, " pulse R3"}, rst_pulse, e.pulse);
        chk(dly_start == e.ds, {e.tag, " dly_start R10"}, dly_start, e.ds);
        chk(wd_cnt == e.wd, {e.tag, " wd count R4"}, wd_cnt, e.wd);
        chk(bus_cnt == e.bus, {e.tag, " bus count R5"}, bus_cnt, e.bus);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk(mode == RST, "reset mode R1", mode, RST);
    chk(pwr_en == 0 && wd_en == 0 && chg_oe == 0, "reset pins R2", pwr_en, 0);
    chk(rst_pulse == 0, "reset pulse low R1", rst_pulse, 0);
    chk(wd_cnt == 0 && bus_cnt == 0, "reset counters R1", wd_cnt, 0);
    arst_n = 1;
    enter_run("R1 release");
    repeat (14) step(RUN, 0, 0, 0, "R3 pulse high");
    step(RUN, 0, 0, 0, "R3 pulse ended");

    tmo = 1; step(RUN, 1, 0, 0, "R4 timeout");
    tmo = 1; step(RUN, 2, 0, 0, "R4 timeout");
    kick = 1; step(RUN, 0, 0, 0, "R4 kick clears");
    tmo = 1; kick = 1; step(RUN, 1, 0, 0, "R4 timeout beats kick");
    for (int i = 2; i <= 5; i++) begin
      tmo = 1; step(RUN, i, 0, 0, "R4 count up");
    end
    tmo = 1; step(RST, 5, 0, 0, "R6 watchdog limit exit, R4 saturate");
    enter_run("R7 re-entry clears");

    for (int i = 1; i <= 5; i++) begin
      berr = 1; step(RUN, 0, i, 0, "R5 bus error");
    end
    step(RST, 0, 5, 0, "R6 bus limit exit");
    enter_run("R1 re-entry");

    wake = 8'hA5; imp = 1; alarm = 1;
    step(RUN, 0, 0, 0, "R8 wake sources ignored in run");
    wake = 8'h00;
    step(RUN, 0, 0, 0, "R8 wake release ignored");

    tmo = 1; step(RUN, 1, 0, 0, "R2 before async reset");
    arst_n = 0;
    #1;
    chk(mode == RST, "async reset mode R1", mode, RST);
    chk(wd_cnt == 0, "async reset counter R1", wd_cnt, 0);
    chk(rst_pulse == 0, "async reset pulse R1", rst_pulse, 0);
    @(negedge clk);
    arst_n = 1;
    enter_run("R1 after async reset");

    sleep = 1; step(WT, 0, 0, 1, "R10 enter wait");
    sleep = 0; tmo = 1; berr = 1;
    step(WT, 0, 0, 0, "R7 strobes ignored in wait");
    wake[0] = 1; step(RST, 0, 0, 0, "R11 wake0 resume");
    wake[0] = 0;
    enter_run("R11 back in run");

    sleep = 1; step(WT, 0, 0, 1, "R10 enter wait");
    sleep = 0; ddone = 1; step(SB, 0, 0, 0, "R11 delay end to standby");
    step(SB, 0, 0, 0, "R12 standby holds");
    tmo = 1; berr = 1; step(SB, 0, 0, 0, "R7 strobes ignored in standby");
    wake[5] = 1; step(RST, 0, 0, 0, "R12 wake change");
    enter_run("R12 back in run");

    sleep = 1; step(WT, 0, 0, 1, "R10 enter wait");
    sleep = 0; res_n = 0; step(SB, 0, 0, 0, "R11 reset line low");
    res_n = 1; step(SB, 0, 0, 0, "R12 steady inputs");
    alarm = 1; step(RST, 0, 0, 0, "R12 alarm wake");
    enter_run("R12 after alarm");

    sleep = 1; step(WT, 0, 0, 1, "R10 enter wait");
    sleep = 0; ddone = 1; step(SB, 0, 0, 0, "R11 delay end");
    imp = 1; step(RST, 0, 0, 0, "R12 impedance wake");
    enter_run("R12 after impedance");

    osc = 1; sleep = 1; step(RST, 0, 0, 0, "R6 oscillator fault beats sleep");
    sleep = 0;
    age = 0;
    step(RUN, 0, 0, 0, "R9 run without ack");
    for (int k = 1; k <= 162; k++) begin
      if (k == 162) begin
        age = 0;
        step(RUN, 0, 0, 0, "R9 re-entry after misses");
      end else if (k == 161) begin
        step(RST, 0, 5, 0, "R9 fifth miss exits");
      end else begin
        step(RUN, 0, k / 32, 0, "R9 missed ack count");
      end
    end
    acc = 1; step(RUN, 0, 0, 0, "R9 ack");
    repeat (40) step(RUN, 0, 0, 0, "R9 no miss after ack");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule